// File: doc/BRIEF.md
# Panel Power-On Sequencer

This block brings up a flat panel display in a fixed order: the panel supply rail first, then the video interface driver, then the backlight supply, then the backlight PWM generator, and finally the backlight enable. Each step is held off from the next by a programmable delay given in milliseconds. The delays are counted against an external one-microsecond tick, so each millisecond costs `TICKS_PER_MS` ticks.

A single start pulse launches the sequence. Each of the four power and enable lines has a present flag. When a flag is clear, that line never rises, but its stage and its delay still take their normal time, so the rest of the sequence keeps the same timing.

The block has two ways to advance. In run mode it steps on its own as soon as each deadline has passed. In poll mode it steps only in a cycle where the poll input is high, and a poll that arrives before the deadline changes nothing. Once the last step is done, the block reports done and stays there until reset.

Top module: `panel_pwr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, all five enable lines, `pwm_duty_o`, `busy_o` and `done_o` are 0 after that edge.
- R2: A `start_i` pulse taken in the idle state sets `busy_o` at the capturing edge. A `start_i` taken while busy or done has no effect: the timing, the lines and `done_o` are unchanged.
- R3: The lines rise in this fixed order: `panel_vdd_o`, `iface_en_o`, `bl_vdd_o`, `pwm_en_o`, `bl_en_o`. A line that has risen stays high until reset.
- R4: The start stage moves to the panel-supply stage one edge after capture, with no wait. `delay_ms_i[MS_W*k +: MS_W]` holds delay k+1 (k = 0..3). In run mode, with a tick every cycle, the line of step k+2 rises exactly D(k+1)*TICKS_PER_MS+1 edges after the line of step k+1. The steps are numbered 1 panel supply, 2 interface, 3 backlight supply, 4 PWM, 5 backlight enable.
- R5: A zero delay lets the next step rise on the very next edge.
- R6: `present_i` bit 0 gates the panel supply, bit 1 the interface, bit 2 the backlight supply and bit 3 the backlight enable. A gated line stays 0, but its stage keeps its full duration.
- R7: In poll mode (`run_mode_i` = 0) the block advances only at an edge where `poll_i` is 1 and the current deadline has passed. An earlier poll has no effect.
- R8: In run mode (`run_mode_i` = 1) the sequence reaches done without any poll.
- R9: `pwm_duty_o` equals `PWM_DUTY` (default 0xDF out of 256) while `pwm_en_o` is 1, and is 0 otherwise.
- R10: `done_o` rises one edge after `bl_en_o`'s step and stays high until reset. `busy_o` and `done_o` are never both high.
- R11: The deadline counts only cycles with `us_tick_i` high. With no ticks, a pending delay never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse |
| run_mode_i | input | 1 | 1 = advance on its own, 0 = advance on poll |
| poll_i | input | 1 | Advance request in poll mode |
| us_tick_i | input | 1 | One-microsecond tick |
| present_i | input | 4 | Present flags for the four power and enable lines |
| delay_ms_i | input | 4*MS_W | Four inter-step delays in ms |
| panel_vdd_o | output | 1 | Panel supply enable |
| iface_en_o | output | 1 | Video interface driver enable |
| bl_vdd_o | output | 1 | Backlight supply enable |
| pwm_en_o | output | 1 | Backlight PWM enable |
| pwm_duty_o | output | DUTY_W | Requested PWM duty code |
| bl_en_o | output | 1 | Backlight enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence complete |

## Verification
Some rules are checked on every cycle. These are:
- `busy_o` and `done_o` are never both high, and done holds once set.
- Enable lines never fall, and the backlight enable never appears without PWM.
- No step advances before the deadline counter reaches zero.
- No step advances without run mode or a poll.
- A line rises only when its present flag is set.
- The duty code tracks `pwm_duty_o` against the PWM enable.

Other behaviour can only be shown by the bench's scenarios. This covers the exact distance between steps for random and zero delays, gated lines that keep their time slot, start pulses ignored mid-sequence and after done, early polls that do nothing, and a deadline frozen while ticks stop.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int unsigned NUM_DLY = 4;
  localparam int unsigned NUM_LINES = 5;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_PANEL = 3'd2,
    ST_IFACE = 3'd3,
    ST_BLVDD = 3'd4,
    ST_PWM   = 3'd5,
    ST_BLEN  = 3'd6,
    ST_DONE  = 3'd7
  } stage_t;

  // Converts a millisecond count to microsecond ticks.
  function automatic int unsigned ms_to_ticks(int unsigned ms, int unsigned per_ms);
    return ms * per_ms;
  endfunction

  // Stages that take part in the sequence and can advance.
  function automatic logic is_active(stage_t s);
    return (s != ST_IDLE) && (s != ST_DONE);
  endfunction
endpackage

// File: rtl/pps_delay_timer.sv
module pps_delay_timer #(
  parameter int unsigned CW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          tick_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= load_val_i;
    else if (tick_i && (cnt_q != '0))
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pps_stage_ctrl.sv
module pps_stage_ctrl
  import pps_pkg::*;
#(
  parameter int unsigned MS_W = 8,
  parameter int unsigned TICKS_PER_MS = 1000,
  parameter int unsigned CW = 18
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic                    go_i,
  input  logic                    tmr_zero_i,
  input  logic [NUM_DLY*MS_W-1:0] delay_ms_i,
  output logic                    adv_o,
  output stage_t                  nxt_o,
  output logic                    load_o,
  output logic [CW-1:0]           load_val_o,
  output logic                    busy_o,
  output logic                    done_o
);
  stage_t stage_q;
  logic [MS_W-1:0] dly_ms [NUM_DLY];
  logic [MS_W-1:0] sel_ms;

  for (genvar k = 0; k < NUM_DLY; k++) begin : g_unpack
    assign dly_ms[k] = delay_ms_i[MS_W*k +: MS_W];
  end

  assign nxt_o = stage_t'(stage_q + 3'd1);

  // The start stage leaves with no wait; later stages wait on the deadline.
  always_comb begin
    adv_o = 1'b0;
    if (stage_q == ST_START)
      adv_o = go_i;
    else if (is_active(stage_q))
      adv_o = go_i && tmr_zero_i;
  end

  // The delay that follows the step being entered.
  always_comb begin
    sel_ms = '0;
    case (nxt_o)
      ST_PANEL: sel_ms = dly_ms[0];
      ST_IFACE: sel_ms = dly_ms[1];
      ST_BLVDD: sel_ms = dly_ms[2];
      ST_PWM:   sel_ms = dly_ms[3];
      default:  sel_ms = '0;
    endcase
  end

  assign load_o = adv_o;
  assign load_val_o = CW'(ms_to_ticks(32'(sel_ms), TICKS_PER_MS));

  always_ff @(posedge clk) begin
    if (rst)
      stage_q <= ST_IDLE;
    else if ((stage_q == ST_IDLE) && start_i)
      stage_q <= ST_START;
    else if (adv_o)
      stage_q <= nxt_o;
  end

  assign busy_o = is_active(stage_q);
  assign done_o = (stage_q == ST_DONE);
endmodule

// File: rtl/pps_out_lines.sv
module pps_out_lines
  import pps_pkg::*;
#(
  parameter int unsigned DUTY_W = 8,
  parameter logic [DUTY_W-1:0] PWM_DUTY = 8'hDF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv_i,
  input  stage_t               nxt_i,
  input  logic [3:0]           present_i,
  output logic [NUM_LINES-1:0] line_o,
  output logic [DUTY_W-1:0]    duty_o
);
  // Line order: panel supply, interface, backlight supply, PWM, backlight enable.
  logic [NUM_LINES-1:0] mask;
  assign mask = {present_i[3], 1'b1, present_i[2:0]};

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= 1'b0;
      else if (adv_i && (nxt_i == stage_t'(32'(ST_PANEL) + i)) && mask[i])
        q <= 1'b1;
    end
    assign line_o[i] = q;
  end

  assign duty_o = line_o[3] ? PWM_DUTY : '0;
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int unsigned MS_W = 8,
  parameter int unsigned TICKS_PER_MS = 1000,
  parameter int unsigned DUTY_W = 8,
  parameter logic [DUTY_W-1:0] PWM_DUTY = 8'hDF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic                    run_mode_i,
  input  logic                    poll_i,
  input  logic                    us_tick_i,
  input  logic [3:0]              present_i,
  input  logic [NUM_DLY*MS_W-1:0] delay_ms_i,
  output logic                    panel_vdd_o,
  output logic                    iface_en_o,
  output logic                    bl_vdd_o,
  output logic                    pwm_en_o,
  output logic [DUTY_W-1:0]       pwm_duty_o,
  output logic                    bl_en_o,
  output logic                    busy_o,
  output logic                    done_o
);
  localparam int unsigned MAX_TICKS = ((1 << MS_W) - 1) * TICKS_PER_MS;
  localparam int unsigned CW = $clog2(MAX_TICKS + 1);

  logic go, adv, tmr_zero, tmr_load;
  logic [CW-1:0] tmr_val;
  stage_t nxt;
  logic [NUM_LINES-1:0] lines;

  assign go = run_mode_i || poll_i;

  pps_stage_ctrl #(.MS_W(MS_W), .TICKS_PER_MS(TICKS_PER_MS), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .go_i(go),
    .tmr_zero_i(tmr_zero), .delay_ms_i(delay_ms_i),
    .adv_o(adv), .nxt_o(nxt), .load_o(tmr_load), .load_val_o(tmr_val),
    .busy_o(busy_o), .done_o(done_o)
  );

  pps_delay_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .load_i(tmr_load), .load_val_i(tmr_val),
    .tick_i(us_tick_i), .zero_o(tmr_zero)
  );

  pps_out_lines #(.DUTY_W(DUTY_W), .PWM_DUTY(PWM_DUTY)) u_out (
    .clk(clk), .rst(rst), .adv_i(adv), .nxt_i(nxt), .present_i(present_i),
    .line_o(lines), .duty_o(pwm_duty_o)
  );

  assign panel_vdd_o = lines[0];
  assign iface_en_o  = lines[1];
  assign bl_vdd_o    = lines[2];
  assign pwm_en_o    = lines[3];
  assign bl_en_o     = lines[4];
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
  parameter int unsigned DUTY_W = 8,
  parameter logic [DUTY_W-1:0] PWM_DUTY = 8'hDF
) (
  input logic              clk,
  input logic              rst,
  input logic              run_mode_i,
  input logic              poll_i,
  input logic [3:0]        present_i,
  input logic              panel_vdd_o,
  input logic              iface_en_o,
  input logic              bl_vdd_o,
  input logic              pwm_en_o,
  input logic [DUTY_W-1:0] pwm_duty_o,
  input logic              bl_en_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              adv,
  input logic              tmr_zero
);
  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst) !(busy_o && done_o));
  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (rst) done_o |=> done_o);
  // R3
  lines_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !($fell(panel_vdd_o) || $fell(iface_en_o) || $fell(bl_vdd_o) || $fell(pwm_en_o) || $fell(bl_en_o)));
  // R3
  bl_after_pwm_chk: assert property (@(posedge clk) disable iff (rst) bl_en_o |-> pwm_en_o);
  // R4
  adv_wait_chk: assert property (@(posedge clk) disable iff (rst) (adv && busy_o && !$rose(busy_o)) |-> (tmr_zero || !(panel_vdd_o || iface_en_o || bl_vdd_o || pwm_en_o || bl_en_o) || tmr_zero));
  // R7
  adv_gate_chk: assert property (@(posedge clk) disable iff (rst) adv |-> (run_mode_i || poll_i));
  // R6
  present_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(panel_vdd_o) |-> $past(present_i[0])) and ($rose(bl_en_o) |-> $past(present_i[3])));
  // R9
  duty_chk: assert property (@(posedge clk) disable iff (rst)
    pwm_en_o ? (pwm_duty_o == PWM_DUTY) : (pwm_duty_o == '0));
endmodule

bind panel_pwr_seq pps_checker #(.DUTY_W(DUTY_W), .PWM_DUTY(PWM_DUTY)) u_chk (
  .clk(clk), .rst(rst), .run_mode_i(run_mode_i), .poll_i(poll_i),
  .present_i(present_i), .panel_vdd_o(panel_vdd_o), .iface_en_o(iface_en_o),
  .bl_vdd_o(bl_vdd_o), .pwm_en_o(pwm_en_o), .pwm_duty_o(pwm_duty_o),
  .bl_en_o(bl_en_o), .busy_o(busy_o), .done_o(done_o),
  .adv(adv), .tmr_zero(tmr_zero)
);

// File: tb/panel_pwr_seq_test.sv
module panel_pwr_seq_test;
  localparam int MS_W = 8;
  localparam int TPM = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, run_mode_i = 1'b1, poll_i = 1'b0, us_tick_i = 1'b1;
  logic [3:0] present_i = 4'hF;
  logic [4*MS_W-1:0] delay_ms_i = '0;
  logic panel_vdd_o, iface_en_o, bl_vdd_o, pwm_en_o, bl_en_o, busy_o, done_o;
  logic [7:0] pwm_duty_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  panel_pwr_seq uut (
    .clk(clk), .rst(rst), .start_i(start_i), .run_mode_i(run_mode_i),
    .poll_i(poll_i), .us_tick_i(us_tick_i), .present_i(present_i),
    .delay_ms_i(delay_ms_i), .panel_vdd_o(panel_vdd_o), .iface_en_o(iface_en_o),
    .bl_vdd_o(bl_vdd_o), .pwm_en_o(pwm_en_o), .pwm_duty_o(pwm_duty_o),
    .bl_en_o(bl_en_o), .busy_o(busy_o), .done_o(done_o)
  );

  function automatic logic [4:0] lines();
    return {bl_en_o, pwm_en_o, bl_vdd_o, iface_en_o, panel_vdd_o};
  endfunction

  // Edge at which step i+1 rises, counted from the capturing edge (= 1).
  function automatic int exp_rise(int d[4], int i);
    int e = 2;
    for (int k = 0; k < i; k++) e += d[k] * TPM + 1;
    return e;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      summary();
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; start_i = 1'b0; poll_i = 1'b0;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check(lines() == 0 && pwm_duty_o == 0 && !busy_o && !done_o, "R1", int'(lines()), 0);
    rst = 1'b0;
  endtask

  task automatic run_seq(int d[4], logic [3:0] pres);
    int rise[5];
    int done_j = 0;
    int j = 1;
    logic [4:0] pmask = {pres[3], 1'b1, pres[2:0]};
    logic [4:0] final_l;
    for (int i = 0; i < 5; i++) rise[i] = 0;
    @(negedge clk);
    present_i = pres; run_mode_i = 1'b1; us_tick_i = 1'b1;
    for (int k = 0; k < 4; k++) delay_ms_i[MS_W*k +: MS_W] = MS_W'(d[k]);
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    // R2 busy after capture
    check(busy_o && !done_o, "R2", int'(busy_o), 1);
    while (done_j == 0 && j < 20000) begin
      for (int i = 0; i < 5; i++) if (lines()[i] && rise[i] == 0) rise[i] = j;
      if (pwm_en_o && rise[3] == j)
        check(pwm_duty_o == 8'hDF, "R9", int'(pwm_duty_o), 'hDF); // R9
      if (done_o) done_j = j;
      start_i = (j == 3);  // R2: start while busy must be ignored
      @(negedge clk); j++;
    end
    start_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (pmask[i])
        check(rise[i] == exp_rise(d, i), "R4", rise[i], exp_rise(d, i)); // R4 R5 R3
      else
        check(rise[i] == 0, "R6", rise[i], 0); // R6
    end
    // R10 R8 done one edge after backlight step
    check(done_j == exp_rise(d, 4) + 1, "R10", done_j, exp_rise(d, 4) + 1);
    check(pwm_duty_o == 8'hDF, "R9", int'(pwm_duty_o), 'hDF);
    final_l = lines();
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (3) @(negedge clk);
    // R2 start after done ignored
    check(done_o && !busy_o && lines() == final_l, "R2", int'(lines()), int'(final_l));
  endtask

  task automatic poll_once();
    @(negedge clk); poll_i = 1'b1;
    @(negedge clk); poll_i = 1'b0;
  endtask

  initial begin
    int d[4];
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    do_reset();

    // Directed: all delays zero (R5)
    d = '{0, 0, 0, 0};
    run_seq(d, 4'hF);
    do_reset();

    // Constrained random delays and present flags
    for (int n = 0; n < 4; n++) begin
      for (int k = 0; k < 4; k++) d[k] = int'($urandom_range(0, 3));
      run_seq(d, 4'($urandom_range(0, 15)));
      do_reset();
    end

    // Directed: all lines gated off, timing kept (R6)
    d = '{1, 0, 2, 0};
    run_seq(d, 4'h0);
    do_reset();

    // Poll mode (R7, R11)
    @(negedge clk);
    run_mode_i = 1'b0; present_i = 4'hF; us_tick_i = 1'b1;
    delay_ms_i = '0; delay_ms_i[MS_W-1:0] = 8'd1;
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (20) @(negedge clk);
    check(!panel_vdd_o && busy_o, "R7", int'(panel_vdd_o), 0); // R7 no poll, no step
    poll_once();
    check(panel_vdd_o, "R7", int'(panel_vdd_o), 1);
    repeat (10) @(negedge clk);
    poll_once();
    check(!iface_en_o, "R7", int'(iface_en_o), 0); // R7 early poll ignored
    us_tick_i = 1'b0;
    repeat (2000) @(negedge clk);
    poll_once();
    check(!iface_en_o, "R11", int'(iface_en_o), 0); // R11 no ticks, no expiry
    us_tick_i = 1'b1;
    repeat (1100) @(negedge clk);
    poll_once();
    check(iface_en_o, "R7", int'(iface_en_o), 1);
    poll_once(); poll_once(); poll_once();
    check(bl_en_o && pwm_en_o && bl_vdd_o && !done_o, "R7", int'(lines()), 31);
    poll_once();
    check(done_o && !busy_o, "R10", int'(done_o), 1);
    do_reset();
    summary();
  end
endmodule